// File: doc/BRIEF.md
# Power gating sequence controller

This block switches the core domain of a small microcontroller on and off. Peripherals and memories sit on a supply that is never switched, so they stay powered the whole time. When software raises a standby request, the controller shuts the core down in a fixed order. It first holds the core in reset. It then isolates the core boundary. Last, it opens the core power switch.

An event from an always-powered peripheral brings the core back, with the steps in reverse order. The controller closes the switch and waits a settle interval. It then drops isolation and finally releases reset.

A one-bit-address write port holds two interval counts. One is the spacing between sequence steps. The other is the settle time after power returns. The block also contains the clamp that drives every isolated core output to logic one. A two-bit mode output reports where the sequence stands.

Top module: `pgate_ctrl`

## Requirements
- R1: After synchronous reset, mode is Active (2'b00), core_pwr_on is 1, iso_en is 0, core_rst is 0, the step count is DEF_STEP and the settle count is DEF_SETTLE.
- R2: A standby_req sampled while mode is Active sets core_rst to 1 and mode to Entering (2'b01) at that same clock edge.
- R3: iso_en (active high) rises exactly step-count cycles after core_rst rises, and is never 1 while core_rst is 0.
- R4: core_pwr_on (1 = switch conducting) falls exactly step-count cycles after iso_en rises, and mode becomes Standby (2'b10) at that same edge. Power is never off without isolation.
- R5: While iso_en is 1, every bit of core_out_iso is 1. While iso_en is 0, core_out_iso equals core_out.
- R6: A wake_evt sampled in Standby sets core_pwr_on to 1 and mode to Waking (2'b11) at that edge. iso_en falls settle-count cycles later. core_rst falls step-count cycles after that, and mode returns to Active at the same edge.
- R7: A write with cfg_we=1 stores cfg_wdata into the step count (cfg_sel=0) or the settle count (cfg_sel=1). A written value of 0 is stored as 1. The new count is used from the next step that starts.
- R8: standby_req has no effect unless mode is Active. wake_evt has no effect while mode is Active or Waking.
- R9: A wake_evt seen during Entering is remembered. Entry completes and Standby is held for one cycle. Wake-up then starts with no further event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Count register write strobe |
| cfg_sel | input | 1 | 0 selects step count, 1 selects settle count |
| cfg_wdata | input | CNT_W | Count value to write |
| standby_req | input | 1 | Software standby request |
| wake_evt | input | 1 | Wake-up event from the always-powered peripherals |
| core_out | input | CORE_W | Raw outputs of the core domain |
| core_pwr_on | output | 1 | Core power switch control, 1 = conducting |
| iso_en | output | 1 | Isolation enable, active high |
| core_rst | output | 1 | Reset held on the core |
| mode | output | 2 | 00 Active, 01 Entering, 10 Standby, 11 Waking |
| core_out_iso | output | CORE_W | Core outputs after the clamp |

## Verification
The bench builds the block with an 8-bit core boundary, 8-bit counts, a default step count of 2 and a default settle count of 4. The small widths make every full standby-and-wake round take only a few dozen cycles. Many rounds can therefore be run with step and settle counts between 1 and 4. These include the one-cycle minimum spacing, the case where a written zero is stored as one, and the one-cycle Standby that follows an early wake.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_ENTER   = 2'd1,
        MODE_STANDBY = 2'd2,
        MODE_WAKE    = 2'd3
    } pg_mode_e;

    typedef enum logic [2:0] {
        PH_ACTIVE,
        PH_ENT_RST,
        PH_ENT_ISO,
        PH_STANDBY,
        PH_WAKE_PWR,
        PH_WAKE_ISO
    } pg_phase_e;

    typedef struct packed {
        logic pwr_on;
        logic iso;
        logic hold_rst;
    } pg_ctrl_t;

    localparam pg_ctrl_t CTRL_RUN = '{pwr_on: 1'b1, iso: 1'b0, hold_rst: 1'b0};

    localparam logic CFG_SEL_STEP   = 1'b0;
    localparam logic CFG_SEL_SETTLE = 1'b1;

    function automatic pg_mode_e phase_mode(input pg_phase_e ph);
        case (ph)
            PH_ENT_RST, PH_ENT_ISO:   return MODE_ENTER;
            PH_STANDBY:               return MODE_STANDBY;
            PH_WAKE_PWR, PH_WAKE_ISO: return MODE_WAKE;
            default:                  return MODE_ACTIVE;
        endcase
    endfunction

endpackage

// File: rtl/pgate_cfg_regs.sv
module pgate_cfg_regs #(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned DEF_STEP   = 2,
    parameter int unsigned DEF_SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] step_cnt,
    output logic [CNT_W-1:0] settle_cnt
);
    import pgate_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] wr_val;

    // a zero count would stall a step, so it is raised to one
    assign wr_val = (cfg_wdata == '0) ? ONE : cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_cnt   <= CNT_W'(DEF_STEP);
            settle_cnt <= CNT_W'(DEF_SETTLE);
        end else if (cfg_we) begin
            if (cfg_sel == CFG_SEL_STEP) step_cnt <= wr_val;
            else                         settle_cnt <= wr_val;
        end
    end

endmodule

// File: rtl/pgate_step_timer.sv
module pgate_step_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (load)           remain <= load_val;
        else if (remain != '0)   remain <= remain - ONE;
    end

    assign done = (remain == ONE);

endmodule

// File: rtl/pgate_seq.sv
module pgate_seq #(
    parameter int unsigned CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  standby_req,
    input  logic                  wake_evt,
    input  logic                  step_done,
    input  logic [CNT_W-1:0]      step_cnt,
    input  logic [CNT_W-1:0]      settle_cnt,
    output pgate_pkg::pg_ctrl_t   ctrl,
    output pgate_pkg::pg_phase_e  phase,
    output logic                  tmr_load,
    output logic [CNT_W-1:0]      tmr_val
);
    import pgate_pkg::*;

    pg_phase_e nxt_phase;
    pg_ctrl_t  nxt_ctrl;
    logic      wake_pend, nxt_pend;

    always_comb begin
        nxt_phase = phase;
        nxt_ctrl  = ctrl;
        nxt_pend  = wake_pend;
        tmr_load  = 1'b0;
        tmr_val   = step_cnt;
        case (phase)
            PH_ACTIVE: begin
                if (standby_req) begin
                    nxt_phase         = PH_ENT_RST;
                    nxt_ctrl.hold_rst = 1'b1;
                    tmr_load          = 1'b1;
                end
            end
            PH_ENT_RST: begin
                nxt_pend = wake_pend | wake_evt;
                if (step_done) begin
                    nxt_phase    = PH_ENT_ISO;
                    nxt_ctrl.iso = 1'b1;
                    tmr_load     = 1'b1;
                end
            end
            PH_ENT_ISO: begin
                nxt_pend = wake_pend | wake_evt;
                if (step_done) begin
                    nxt_phase       = PH_STANDBY;
                    nxt_ctrl.pwr_on = 1'b0;
                end
            end
            PH_STANDBY: begin
                if (wake_evt || wake_pend) begin
                    nxt_phase       = PH_WAKE_PWR;
                    nxt_ctrl.pwr_on = 1'b1;
                    nxt_pend        = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_val         = settle_cnt;
                end
            end
            PH_WAKE_PWR: begin
                if (step_done) begin
                    nxt_phase    = PH_WAKE_ISO;
                    nxt_ctrl.iso = 1'b0;
                    tmr_load     = 1'b1;
                end
            end
            PH_WAKE_ISO: begin
                if (step_done) begin
                    nxt_phase         = PH_ACTIVE;
                    nxt_ctrl.hold_rst = 1'b0;
                end
            end
            default: begin
                nxt_phase = PH_ACTIVE;
                nxt_ctrl  = CTRL_RUN;
                nxt_pend  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_ACTIVE;
            ctrl      <= CTRL_RUN;
            wake_pend <= 1'b0;
        end else begin
            phase     <= nxt_phase;
            ctrl      <= nxt_ctrl;
            wake_pend <= nxt_pend;
        end
    end

endmodule

// File: rtl/pgate_clamp.sv
module pgate_clamp #(
    parameter int unsigned CORE_W = 8
) (
    input  logic              iso_en,
    input  logic [CORE_W-1:0] raw_in,
    output logic [CORE_W-1:0] held_out
);
    for (genvar b = 0; b < CORE_W; b++) begin : g_bit
        assign held_out[b] = iso_en | raw_in[b];
    end

endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl #(
    parameter int unsigned CORE_W     = 8,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned DEF_STEP   = 2,
    parameter int unsigned DEF_SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              standby_req,
    input  logic              wake_evt,
    input  logic [CORE_W-1:0] core_out,
    output logic              core_pwr_on,
    output logic              iso_en,
    output logic              core_rst,
    output logic [1:0]        mode,
    output logic [CORE_W-1:0] core_out_iso
);
    import pgate_pkg::*;

    logic [CNT_W-1:0] step_cnt, settle_cnt, tmr_val;
    logic             tmr_load, step_done;
    pg_ctrl_t         ctrl;
    pg_phase_e        phase;

    pgate_cfg_regs #(
        .CNT_W(CNT_W), .DEF_STEP(DEF_STEP), .DEF_SETTLE(DEF_SETTLE)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .step_cnt(step_cnt), .settle_cnt(settle_cnt)
    );

    pgate_step_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .done(step_done)
    );

    pgate_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .standby_req(standby_req), .wake_evt(wake_evt),
        .step_done(step_done), .step_cnt(step_cnt), .settle_cnt(settle_cnt),
        .ctrl(ctrl), .phase(phase), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    pgate_clamp #(.CORE_W(CORE_W)) u_clamp (
        .iso_en(ctrl.iso), .raw_in(core_out), .held_out(core_out_iso)
    );

    assign core_pwr_on = ctrl.pwr_on;
    assign iso_en      = ctrl.iso;
    assign core_rst    = ctrl.hold_rst;
    assign mode        = phase_mode(phase);

endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
    parameter int unsigned CORE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              standby_req,
    input logic              core_pwr_on,
    input logic              iso_en,
    input logic              core_rst,
    input logic [1:0]        mode,
    input logic [CORE_W-1:0] core_out,
    input logic [CORE_W-1:0] core_out_iso
);
    // R2
    entry_start_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && standby_req) |=> (mode == 2'd1 && core_rst));

    // R3
    iso_needs_rst_chk: assert property (@(posedge clk) disable iff (rst)
        iso_en |-> core_rst);

    // R3
    rst_before_iso_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(iso_en) |-> $past(core_rst));

    // R4
    off_needs_iso_chk: assert property (@(posedge clk) disable iff (rst)
        !core_pwr_on |-> iso_en);

    // R4
    standby_unpowered_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |-> !core_pwr_on);

    // R5
    clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
        iso_en |-> (&core_out_iso));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        !iso_en |-> (core_out_iso == core_out));

    // R6
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (core_pwr_on && !iso_en && mode == 2'd0));

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !standby_req) |=> (mode == 2'd0));

endmodule

bind pgate_ctrl pgate_ctrl_chk #(.CORE_W(CORE_W)) u_chk (
    .clk(clk), .rst(rst), .standby_req(standby_req),
    .core_pwr_on(core_pwr_on), .iso_en(iso_en), .core_rst(core_rst),
    .mode(mode), .core_out(core_out), .core_out_iso(core_out_iso)
);

// File: tb/pgate_ctrl_bench.sv
module pgate_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CORE_W     = 8;
    localparam int CNT_W      = 8;
    localparam logic [CORE_W-1:0] RAW = 8'h5A;
    // rows: step count, settle count, early wake (1) or late wake (0)
    localparam int NVEC = 5;
    localparam int VEC [NVEC][3] = '{
        '{1, 1, 0}, '{2, 3, 0}, '{3, 1, 1}, '{1, 4, 1}, '{4, 2, 0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [CNT_W-1:0]  cfg_wdata = '0;
    logic              standby_req = 1'b0;
    logic              wake_evt = 1'b0;
    logic [CORE_W-1:0] core_out = RAW;
    logic              core_pwr_on, iso_en, core_rst;
    logic [1:0]        mode;
    logic [CORE_W-1:0] core_out_iso;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    pgate_ctrl #(.CORE_W(CORE_W), .CNT_W(CNT_W), .DEF_STEP(2), .DEF_SETTLE(4)) u_pgate_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .standby_req(standby_req), .wake_evt(wake_evt),
        .core_out(core_out), .core_pwr_on(core_pwr_on), .iso_en(iso_en),
        .core_rst(core_rst), .mode(mode), .core_out_iso(core_out_iso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [CNT_W-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // starts and ends at a falling edge with mode Active
    task automatic run_round(input int d, input int s, input bit early);
        standby_req = 1'b1;
        @(negedge clk);
        standby_req = 1'b0;
        chk("R2 mode", mode, 2'd1);
        chk("R2 core_rst", core_rst, 1'b1);
        chk("R3 iso low at start", iso_en, 1'b0);
        if (early) begin
            wake_evt = 1'b1;
            standby_req = 1'b1;   // R8: ignored while entering
        end
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            wake_evt = 1'b0;
            standby_req = 1'b0;
            if (k < d) chk("R3 iso not yet", iso_en, 1'b0);
        end
        chk("R3 iso asserted", iso_en, 1'b1);
        chk("R5 clamp entering", core_out_iso, 8'hFF);
        for (int k = 1; k < d; k++) @(negedge clk);
        chk("R4 power still on", core_pwr_on, 1'b1);
        @(negedge clk);
        chk("R4 power off", core_pwr_on, 1'b0);
        chk("R4 mode standby", mode, 2'd2);
        if (early) begin
            @(negedge clk);
            chk("R9 wake after one standby cycle", {mode, core_pwr_on}, {2'd3, 1'b1});
        end else begin
            repeat (3) @(negedge clk);
            chk("R4 standby held", {mode, core_pwr_on}, {2'd2, 1'b0});
            chk("R5 clamp in standby", core_out_iso, 8'hFF);
            wake_evt = 1'b1;
            @(negedge clk);
            wake_evt = 1'b0;
            chk("R6 wake power on", {mode, core_pwr_on}, {2'd3, 1'b1});
        end
        chk("R6 iso held at wake", iso_en, 1'b1);
        standby_req = 1'b1;       // R8: ignored while waking
        for (int k = 1; k <= s; k++) begin
            @(negedge clk);
            standby_req = 1'b0;
            if (k < s) chk("R6 iso during settle", iso_en, 1'b1);
        end
        chk("R6 iso released", iso_en, 1'b0);
        chk("R6 rst still held", core_rst, 1'b1);
        chk("R5 pass after iso", core_out_iso, RAW);
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            if (k < d) chk("R6 rst still held", core_rst, 1'b1);
        end
        chk("R6 rst released", {mode, core_rst}, {2'd0, 1'b0});
        repeat (2) @(negedge clk);
        chk("R8 stays active", mode, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 mode", mode, 2'd0);
        chk("R1 pwr", core_pwr_on, 1'b1);
        chk("R1 iso", iso_en, 1'b0);
        chk("R1 rst", core_rst, 1'b0);
        chk("R5 pass active", core_out_iso, RAW);

        // R1 R7: default counts 2 and 4
        run_round(2, 4, 1'b0);

        // R8: wake in Active has no effect and leaves no memory
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        chk("R8 wake ignored", {mode, core_pwr_on}, {2'd0, 1'b1});
        core_out = 8'h3C;
        @(negedge clk);
        chk("R5 pass new value", core_out_iso, 8'h3C);
        core_out = RAW;

        for (int v = 0; v < NVEC; v++) begin
            cfg_write(1'b0, CNT_W'(VEC[v][0]));
            cfg_write(1'b1, CNT_W'(VEC[v][1]));
            run_round(VEC[v][0], VEC[v][2] == 1 ? VEC[v][1] : VEC[v][1], VEC[v][2] != 0);
        end

        // R7: zero written is stored as one
        cfg_write(1'b0, '0);
        cfg_write(1'b1, '0);
        run_round(1, 1, 1'b0);

        // R1: reset in Standby returns to the power-on state and defaults
        standby_req = 1'b1;
        @(negedge clk);
        standby_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 standby before reset", mode, 2'd2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset from standby", {mode, core_pwr_on, iso_en, core_rst}, {2'd0, 3'b100});
        run_round(2, 4, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule